// File: doc/BRIEF.md
# Serial boot configuration loader

After power comes up, this block reads a fixed-length run of configuration bits from an external serial memory and holds them in a register for the rest of the chip. It is held idle while `pwr_good` is low. As soon as `pwr_good` rises, it starts a slow serial clock on `mode_clk` by dividing the system clock. On each rising edge of that clock it shifts one bit from `mode_din` into the configuration register. The first bit received becomes bit 0.

Once the last bit is in, `cfg_done` goes high. Downstream logic uses this flag as its reset release. The register then stays frozen until `pwr_good` falls. The low bits of the word are also decoded into a core clock multiplier code and a reserved-value error flag.

The external memory must present each bit at least four system clocks before the sampling edge. No hold time is required.

Top module: `boot_cfg_loader`

## Requirements
- R1: While `pwr_good` is low, all outputs are zero: `mode_clk`, `cfg_done`, `rsvd_err`, `cfg_word`, `mult_code` and `mult_x2`.
- R2: `mode_clk` has a period of CLK_DIV system clocks and is high for the upper half of each period. It first goes high CLK_DIV/2 rising edges after `pwr_good` rises, and it keeps running after `cfg_done`.
- R3: `mode_din` is sampled only at the system clock edge where `mode_clk` rises. Values that are present only between sampling edges have no effect on `cfg_word`.
- R4: The k-th bit sampled, counting from 0, lands in `cfg_word[k]`. Exactly CFG_BITS bits are taken.
- R5: `cfg_done` rises at the edge that captures the last bit. This is edge CLK_DIV/2 + (CFG_BITS-1)*CLK_DIV after `pwr_good` rises.
- R6: After `cfg_done`, both `cfg_word` and `cfg_done` hold whatever `mode_din` does. A low then high pulse on `pwr_good` restarts the load.
- R7: When `cfg_done` is high, `mult_code` equals bits 3:1 of the word. `mult_x2` is twice the multiplier, and the multiplier is the code plus 2. The exception is when bit 4 is 1 and the code is 3, 5 or 7: then the multiplier is half of that value (2.5, 3.5 or 4.5). Both outputs are zero while `cfg_done` is low.
- R8: `rsvd_err` is high exactly when `cfg_done` is high and either of two conditions holds. The first is that bit 0 is 1. The second is that bit 4 is 1 while the code is not 3, 5 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power-good; low holds the block reset, rising starts a load |
| mode_din | input | 1 | Serial configuration data from external memory |
| mode_clk | output | 1 | Divided serial clock for the external memory |
| cfg_word | output | CFG_BITS | Captured configuration word |
| cfg_done | output | 1 | Load complete; downstream reset release |
| mult_code | output | 3 | Raw multiplier code, valid with `cfg_done` |
| mult_x2 | output | 5 | Twice the core clock multiplier, valid with `cfg_done` |
| rsvd_err | output | 1 | Illegal reserved value in the captured word |

## Verification
The bench builds the block with CFG_BITS = 16 and CLK_DIV = 16. This makes a full load take about 250 clocks, so every value of the low five decoded bits can be loaded in turn, 32 loads in all. Each load passes through a power-good drop, a complete serial load and a hold period. Between sampling edges the bench drives the inverse of the next bit, which exposes any sampling away from the mode clock's rising edge. It toggles the data line after the load to confirm the freeze. The divided clock and the done flag are compared against their arithmetic schedule on every cycle of every load.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    localparam int RSVD_POS  = 0;
    localparam int CODE_LSB  = 1;
    localparam int CODE_W    = 3;
    localparam int HALF_POS  = 4;
    localparam int DEC_BITS  = 5;
    localparam int X2_W      = 5;

    // Codes with a half-step variant: 3, 5 and 7.
    function automatic logic half_allowed(input logic [CODE_W-1:0] code);
        return code[0] && (code != 3'd1);
    endfunction

    function automatic logic [X2_W-1:0] mult_twice(input logic [CODE_W-1:0] code,
                                                   input logic              half);
        logic [X2_W-1:0] base;
        base = {2'b00, code} + 5'd2;
        return (half && half_allowed(code)) ? base : (base << 1);
    endfunction

endpackage

// File: rtl/bcl_clkdiv.sv
module bcl_clkdiv #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic pwr_good,
    output logic mode_clk,
    output logic sample_stb
);
    localparam int DIV_W = $clog2(DIV);
    localparam int HALF  = DIV / 2;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.div = s_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) s_q <= '0;
        else           s_q <= s_d;
    end

    assign mode_clk   = s_q.div[DIV_W-1];
    assign sample_stb = (s_q.div == DIV_W'(HALF - 1));

    AST_STB_PRECEDES_RISE: assert property (@(posedge clk) disable iff (!pwr_good)
        sample_stb |=> (mode_clk && !$past(mode_clk)));                // R3
    AST_CLK_LOW_AFTER_WRAP: assert property (@(posedge clk) disable iff (!pwr_good)
        (s_q.div == DIV_W'(DIV - 1)) |=> !mode_clk);                     // R2

endmodule

// File: rtl/bcl_shifter.sv
module bcl_shifter #(
    parameter int N = 256
) (
    input  logic         clk,
    input  logic         pwr_good,
    input  logic         sample_stb,
    input  logic         din,
    output logic [N-1:0] cfg,
    output logic         done
);
    localparam int CNT_W = $clog2(N + 1);

    typedef struct packed {
        logic [N-1:0]     cfg;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } sh_st_t;

    sh_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sample_stb && !s_q.done) begin
            s_d.cfg  = {din, s_q.cfg[N-1:1]};
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.done = (s_q.cnt == CNT_W'(N - 1));
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) s_q <= '0;
        else           s_q <= s_d;
    end

    assign cfg  = s_q.cfg;
    assign done = s_q.done;

    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!pwr_good)
        done |=> (done && $stable(cfg)));                                // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!pwr_good)
        !done |-> (s_q.cnt < CNT_W'(N)));                                // R5
    AST_HOLD_WITHOUT_STB: assert property (@(posedge clk) disable iff (!pwr_good)
        !sample_stb |=> $stable(cfg));                                   // R3

endmodule

// File: rtl/bcl_decode.sv
module bcl_decode
    import bcl_pkg::*;
(
    input  logic [DEC_BITS-1:0] low_bits,
    input  logic                done,
    output logic [CODE_W-1:0]   mult_code,
    output logic [X2_W-1:0]     mult_x2,
    output logic                rsvd_err
);
    logic [CODE_W-1:0] code;
    logic              half;

    always_comb begin
        code      = low_bits[CODE_LSB +: CODE_W];
        half      = low_bits[HALF_POS];
        mult_code = done ? code : '0;
        mult_x2   = done ? mult_twice(code, half) : '0;
        rsvd_err  = done && (low_bits[RSVD_POS] || (half && !half_allowed(code)));
    end

endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
    import bcl_pkg::*;
#(
    parameter int CFG_BITS = 256,
    parameter int CLK_DIV  = 256
) (
    input  logic                clk,
    input  logic                pwr_good,
    input  logic                mode_din,
    output logic                mode_clk,
    output logic [CFG_BITS-1:0] cfg_word,
    output logic                cfg_done,
    output logic [2:0]          mult_code,
    output logic [4:0]          mult_x2,
    output logic                rsvd_err
);
    logic sample_stb;

    bcl_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .mode_clk   (mode_clk),
        .sample_stb (sample_stb)
    );

    bcl_shifter #(.N(CFG_BITS)) u_shift (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .sample_stb (sample_stb),
        .din        (mode_din),
        .cfg        (cfg_word),
        .done       (cfg_done)
    );

    bcl_decode u_dec (
        .low_bits  (cfg_word[DEC_BITS-1:0]),
        .done      (cfg_done),
        .mult_code (mult_code),
        .mult_x2   (mult_x2),
        .rsvd_err  (rsvd_err)
    );

    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!pwr_good)
        rsvd_err |-> cfg_done);                                          // R8
    AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!pwr_good)
        cfg_done |-> (mult_x2 >= 5'd4 && mult_x2 <= 5'd18));              // R7
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(cfg_done) |-> 1'b0);                                       // R6

endmodule

// File: tb/boot_cfg_loader_test.sv
module boot_cfg_loader_test;
    localparam int N    = 16;
    localparam int DIV  = 16;
    localparam int HALF = DIV / 2;
    localparam int LAST = HALF + DIV * (N - 1);

    logic         clk = 1'b0;
    logic         pwr_good = 1'b0;
    logic         mode_din = 1'b0;
    logic         mode_clk;
    logic [N-1:0] cfg_word;
    logic         cfg_done;
    logic [2:0]   mult_code;
    logic [4:0]   mult_x2;
    logic         rsvd_err;

    int checks = 0;
    int fails  = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    boot_cfg_loader #(.CFG_BITS(N), .CLK_DIV(DIV)) uut (
        .clk(clk), .pwr_good(pwr_good), .mode_din(mode_din),
        .mode_clk(mode_clk), .cfg_word(cfg_word), .cfg_done(cfg_done),
        .mult_code(mult_code), .mult_x2(mult_x2), .rsvd_err(rsvd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            logic [N-1:0] w;
            logic [2:0]   code;
            logic [4:0]   base;
            logic [4:0]   ex2;
            logic         hok;
            w    = {11'(k * 613 + 677), 5'(k)};
            code = w[3:1];
            base = 5'(code) + 5'd2;
            hok  = (code == 3'd3) || (code == 3'd5) || (code == 3'd7);
            ex2  = (w[4] && hok) ? base : 5'(base * 2);

            pwr_good = 1'b0;
            mode_din = 1'b0;
            repeat (3) @(negedge clk);
            chk("R1 mode_clk", 32'(mode_clk), 0);
            chk("R1 cfg_done", 32'(cfg_done), 0);
            chk("R1 rsvd_err", 32'(rsvd_err), 0);
            chk("R1 cfg_word", 32'(cfg_word), 0);
            chk("R1 mult_x2", 32'(mult_x2), 0);
            chk("R1 mult_code", 32'(mult_code), 0);

            pwr_good = 1'b1;
            mode_din = w[0];
            for (int e = 1; e <= LAST + 2 * DIV; e++) begin
                @(negedge clk);
                chk("R2 mode_clk", 32'(mode_clk), 32'((e % DIV) >= HALF));
                chk("R5 cfg_done", 32'(cfg_done), 32'(e >= LAST));
                if (e == LAST) chk("R4 R3 cfg_word at done", 32'(cfg_word), 32'(w));
                if (e >= LAST) begin
                    mode_din = e[0];          // R6: activity after done
                end else if (e >= HALF) begin
                    int ph;
                    int i;
                    ph = (e - HALF) % DIV;
                    i  = (e - HALF) / DIV;
                    if (ph == 0) mode_din = ~w[i + 1];   // R3: junk between samples
                    if (ph == 2) mode_din = w[i + 1];
                end
            end
            chk("R6 cfg_word held", 32'(cfg_word), 32'(w));
            chk("R6 cfg_done held", 32'(cfg_done), 1);
            chk("R7 mult_code", 32'(mult_code), 32'(code));
            chk("R7 mult_x2", 32'(mult_x2), 32'(ex2));
            chk("R8 rsvd_err", 32'(rsvd_err), 32'(w[0] || (w[4] && !hok)));
        end
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R1 cfg_done after drop", 32'(cfg_done), 0);
        summary();
        $finish;
    end

endmodule